// File: doc/BRIEF.md
# Special-Function Output Pin Multiplexer

This block places internal timing signals on five general-purpose output pins. Four pins idle high: an LCD line clock, an LCD frame signal, a timer output and a programmable divided clock. One pin idles low: a buzzer tone. Each pin merges its port data bit, supplied from outside, with its special signal. The special signal passes only while that pin's enable bit is set. Software controls the block over a byte-wide register bus with a combinational read port. For the special signal to appear cleanly, software keeps the pin's data bit at the idle level.

The divided-clock pin has its own generator. A 3-bit select field picks one of two oscillator inputs (`osc1`, `osc3`) and a ratio of 1, 2, 4 or 8. Both oscillator inputs are slow level signals sampled on `clk`.

The generator is a three-state machine. DIV_IDLE holds the output high while the pin is disabled. Setting the enable takes DIV_IDLE to DIV_ARM. DIV_ARM holds the output high, captures the current select value and waits for a rising edge of the chosen source. That edge takes it to DIV_RUN and clears the ratio counter. In DIV_RUN the counter advances on every source rising edge. A changed select value takes DIV_RUN back to DIV_ARM, but only while the output is high. Clearing the enable takes DIV_ARM or DIV_RUN straight to DIV_IDLE.

Top module: `sfo_outmux`

## Requirements
- R1: After reset all enable bits and the select field are 0. Every register reads 0x00, `pin_out[3:0]` equals `pin_data[3:0]` and `pin_out[4]` equals `pin_data[4]`, whatever the special inputs are.
- R2: Register 0x10 bit 4 enables the line clock. While it is set, `pin_out[0] = pin_data[0] & sig_lcd_line`. While it is clear, `pin_out[0] = pin_data[0]`. This path is combinational.
- R3: Register 0x10 bit 3 enables the frame signal on `pin_out[1]`, using the same AND rule with `sig_lcd_frame`.
- R4: Register 0x30 bit 2 enables the timer output on `pin_out[2]`, using the same AND rule with `sig_timer`.
- R5: Register 0x44 bit 0 enables the buzzer. While it is set, `pin_out[4] = pin_data[4] | sig_buzz`. While it is clear, `pin_out[4] = pin_data[4]`.
- R6: The defined bits read back the last value written: 0x10 bits 4 and 3, 0x30 bit 2, 0x40 bits 6:3, and 0x44 bit 0. All other bits, and all other addresses, read 0 and ignore writes.
- R7: Register 0x40 bit 3 enables the divided clock on `pin_out[3]`, which uses the AND rule. While it is clear, `pin_out[3] = pin_data[3]`.
- R8: Register 0x40 bits 6:4 form the select field. Bit 6 chooses the source: 0 selects `osc1` and 1 selects `osc3`. Bits 5:4 hold n, and the output period is 2^n source periods. For n ≥ 1 the duty cycle is 50%. For n = 0 the output follows the source level.
- R9: After the enable is set, the output stays high until the first rising edge of the selected source. Its first low phase then has the full steady length.
- R10: A select change written while the output is low takes effect only when the output next rises, so that low phase keeps its full old length. The new setting then runs with its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_data | input | 5 | Port data bits: [0] line, [1] frame, [2] timer, [3] divided clock, [4] buzzer |
| sig_lcd_line | input | 1 | LCD line clock |
| sig_lcd_frame | input | 1 | LCD frame signal |
| sig_timer | input | 1 | Timer output clock |
| sig_buzz | input | 1 | Buzzer tone |
| osc1 | input | 1 | Slow oscillator level |
| osc3 | input | 1 | Fast oscillator level |
| pin_out | output | 5 | Pin levels, bit order as `pin_data` |

## Verification
A bus write to the select field can land in the same cycle range as the generator's own edge-driven phase progress. That collision is the delicate case.

The bench lets the generator run on slow `osc1` divided by 8 and waits until the pin is low. It then writes a fast `osc3` divide-by-1 setting mid-phase. It judges the result by measuring that low phase: it must still last exactly four `osc1` periods. The following periods must match the new setting. A similar measurement after enabling from idle checks that the first low phase is full length.

// File: rtl/sfo_pkg.sv
package sfo_pkg;

    localparam int PIN_N     = 5;
    localparam int PIN_LINE  = 0;
    localparam int PIN_FRAME = 1;
    localparam int PIN_TMR   = 2;
    localparam int PIN_FOUT  = 3;
    localparam int PIN_BUZ   = 4;

    // pins whose idle level is high
    localparam logic [PIN_N-1:0] IDLE_HIGH_MASK = 5'b01111;

    // bit positions inside the control bytes
    localparam int LINE_EN_BIT  = 4;
    localparam int FRAME_EN_BIT = 3;
    localparam int TMR_EN_BIT   = 2;
    localparam int FOUT_EN_BIT  = 3;
    localparam int FSEL_LSB     = 4;
    localparam int BUZ_EN_BIT   = 0;

    localparam int RATIO_W = 2;
    localparam int FSEL_W  = RATIO_W + 1;
    localparam int CNT_W   = (1 << RATIO_W) - 1;

    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_ARM  = 2'd1,
        DIV_RUN  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic              line_en;
        logic              frame_en;
        logic              tmr_en;
        logic              fout_en;
        logic [FSEL_W-1:0] fsel;
        logic              buz_en;
    } ctl_t;

endpackage

// File: rtl/sfo_regs.sv
module sfo_regs
    import sfo_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  A_LCD  = 8'h10,
    parameter logic [7:0]  A_TMR  = 8'h30,
    parameter logic [7:0]  A_FOUT = 8'h40,
    parameter logic [7:0]  A_BUZ  = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctl_t              ctl
);

    localparam logic [ADDR_W-1:0] AD_LCD  = ADDR_W'(A_LCD);
    localparam logic [ADDR_W-1:0] AD_TMR  = ADDR_W'(A_TMR);
    localparam logic [ADDR_W-1:0] AD_FOUT = ADDR_W'(A_FOUT);
    localparam logic [ADDR_W-1:0] AD_BUZ  = ADDR_W'(A_BUZ);

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            if (addr == AD_LCD) begin
                ctl_q.line_en  <= wdata[LINE_EN_BIT];
                ctl_q.frame_en <= wdata[FRAME_EN_BIT];
            end
            if (addr == AD_TMR) begin
                ctl_q.tmr_en <= wdata[TMR_EN_BIT];
            end
            if (addr == AD_FOUT) begin
                ctl_q.fout_en <= wdata[FOUT_EN_BIT];
                ctl_q.fsel    <= wdata[FSEL_LSB +: FSEL_W];
            end
            if (addr == AD_BUZ) begin
                ctl_q.buz_en <= wdata[BUZ_EN_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AD_LCD) begin
            rdata[LINE_EN_BIT]  = ctl_q.line_en;
            rdata[FRAME_EN_BIT] = ctl_q.frame_en;
        end else if (addr == AD_TMR) begin
            rdata[TMR_EN_BIT] = ctl_q.tmr_en;
        end else if (addr == AD_FOUT) begin
            rdata[FOUT_EN_BIT]           = ctl_q.fout_en;
            rdata[FSEL_LSB +: FSEL_W]    = ctl_q.fsel;
        end else if (addr == AD_BUZ) begin
            rdata[BUZ_EN_BIT] = ctl_q.buz_en;
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/sfo_clkdiv.sv
module sfo_clkdiv
    import sfo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc1,
    input  logic              osc3,
    input  logic              en,
    input  logic [FSEL_W-1:0] sel,
    output logic              gen_out,
    output div_state_e        state_o,
    output logic              rise_o,
    output logic [FSEL_W-1:0] sel_run_o
);

    localparam int SRC_BIT = FSEL_W - 1;

    div_state_e         state_q;
    div_state_e         state_d;
    logic [FSEL_W-1:0]  sel_run_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               osc1_q;
    logic               osc3_q;
    logic               src_now;
    logic               src_prev;
    logic               rise;
    logic               raw;
    logic [RATIO_W-1:0] ratio;

    assign ratio    = sel_run_q[RATIO_W-1:0];
    assign src_now  = sel_run_q[SRC_BIT] ? osc3   : osc1;
    assign src_prev = sel_run_q[SRC_BIT] ? osc3_q : osc1_q;
    assign rise     = src_now & ~src_prev;

    // divided level before the state gate
    always_comb begin
        raw = src_now;
        for (int k = 1; k <= CNT_W; k++) begin
            if (int'(ratio) == k) begin
                raw = ~cnt_q[k-1];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE: begin
                if (en) state_d = DIV_ARM;
            end
            DIV_ARM: begin
                if (!en)       state_d = DIV_IDLE;
                else if (rise) state_d = DIV_RUN;
            end
            DIV_RUN: begin
                if (!en)                          state_d = DIV_IDLE;
                else if ((sel != sel_run_q) && raw) state_d = DIV_ARM;
            end
            default: state_d = DIV_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_run_q <= '0;
            cnt_q     <= '0;
            osc1_q    <= 1'b0;
            osc3_q    <= 1'b0;
        end else begin
            osc1_q <= osc1;
            osc3_q <= osc3;
            if (state_d == DIV_ARM) begin
                sel_run_q <= sel;
            end
            if (rise) begin
                if (state_q == DIV_ARM) begin
                    cnt_q <= '0;
                end else if (state_q == DIV_RUN) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        gen_out = 1'b1;
        unique case (state_q)
            DIV_IDLE: gen_out = 1'b1;
            DIV_ARM:  gen_out = 1'b1;
            DIV_RUN:  gen_out = raw;
            default:  gen_out = 1'b1;
        endcase
    end

    assign state_o   = state_q;
    assign rise_o    = rise;
    assign sel_run_o = sel_run_q;

endmodule

// File: rtl/sfo_pinmux.sv
module sfo_pinmux
    import sfo_pkg::*;
#(
    parameter int               N         = PIN_N,
    parameter logic [N-1:0]     IDLE_HIGH = IDLE_HIGH_MASK
) (
    input  logic [N-1:0] data,
    input  logic [N-1:0] sig,
    input  logic [N-1:0] en,
    output logic [N-1:0] pin
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        if (IDLE_HIGH[i]) begin : g_hi
            assign pin[i] = data[i] & (en[i] ? sig[i] : 1'b1);
        end else begin : g_lo
            assign pin[i] = data[i] | (en[i] & sig[i]);
        end
    end

endmodule

// File: rtl/sfo_outmux.sv
module sfo_outmux
    import sfo_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter int         DATA_W = 8,
    parameter logic [7:0] A_LCD  = 8'h10,
    parameter logic [7:0] A_TMR  = 8'h30,
    parameter logic [7:0] A_FOUT = 8'h40,
    parameter logic [7:0] A_BUZ  = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_N-1:0]  pin_data,
    input  logic              sig_lcd_line,
    input  logic              sig_lcd_frame,
    input  logic              sig_timer,
    input  logic              sig_buzz,
    input  logic              osc1,
    input  logic              osc3,
    output logic [PIN_N-1:0]  pin_out
);

    ctl_t              ctl_w;
    logic              div_out_w;
    div_state_e        div_state_w;
    logic              div_rise_w;
    logic [FSEL_W-1:0] div_sel_run_w;
    logic [PIN_N-1:0]  en_w;
    logic [PIN_N-1:0]  sig_w;

    sfo_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .A_LCD  (A_LCD),
        .A_TMR  (A_TMR),
        .A_FOUT (A_FOUT),
        .A_BUZ  (A_BUZ)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .ctl   (ctl_w)
    );

    sfo_clkdiv u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc1      (osc1),
        .osc3      (osc3),
        .en        (ctl_w.fout_en),
        .sel       (ctl_w.fsel),
        .gen_out   (div_out_w),
        .state_o   (div_state_w),
        .rise_o    (div_rise_w),
        .sel_run_o (div_sel_run_w)
    );

    always_comb begin
        en_w            = '0;
        sig_w           = '0;
        en_w[PIN_LINE]  = ctl_w.line_en;
        en_w[PIN_FRAME] = ctl_w.frame_en;
        en_w[PIN_TMR]   = ctl_w.tmr_en;
        en_w[PIN_FOUT]  = ctl_w.fout_en;
        en_w[PIN_BUZ]   = ctl_w.buz_en;
        sig_w[PIN_LINE]  = sig_lcd_line;
        sig_w[PIN_FRAME] = sig_lcd_frame;
        sig_w[PIN_TMR]   = sig_timer;
        sig_w[PIN_FOUT]  = div_out_w;
        sig_w[PIN_BUZ]   = sig_buzz;
    end

    sfo_pinmux #(
        .N         (PIN_N),
        .IDLE_HIGH (IDLE_HIGH_MASK)
    ) u_pins (
        .data (pin_data),
        .sig  (sig_w),
        .en   (en_w),
        .pin  (pin_out)
    );

endmodule

// File: rtl/sfo_outmux_chk.sv
module sfo_outmux_chk
    import sfo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PIN_N-1:0]  pin_data,
    input logic [PIN_N-1:0]  pin_out,
    input ctl_t              ctl,
    input div_state_e        st,
    input logic              div_out,
    input logic              div_rise,
    input logic [FSEL_W-1:0] sel_run
);

    // R2
    line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.line_en |-> (pin_out[PIN_LINE] == pin_data[PIN_LINE]));

    // R5
    buzz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.buz_en |-> (pin_out[PIN_BUZ] == pin_data[PIN_BUZ]));

    // R7
    fout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.fout_en |-> (pin_out[PIN_FOUT] == pin_data[PIN_FOUT]));

    // R8
    fout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DIV_RUN && $past(st) == DIV_RUN && sel_run[RATIO_W-1:0] != '0
         && !$past(div_rise)) |-> $stable(div_out));

    // R9
    fout_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DIV_IDLE && ctl.fout_en) |=> (st == DIV_ARM));

    // R10
    fout_lowhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DIV_RUN && !div_out) |=> (st != DIV_ARM));

endmodule

bind sfo_outmux sfo_outmux_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_data (pin_data),
    .pin_out  (pin_out),
    .ctl      (ctl_w),
    .st       (div_state_w),
    .div_out  (div_out_w),
    .div_rise (div_rise_w),
    .sel_run  (div_sel_run_w)
);

// File: tb/sim_sfo_outmux.sv
module sim_sfo_outmux;

    localparam int OSC1_HALF = 12;
    localparam int OSC3_HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [4:0] pin_data = 5'b01111;
    logic       sig_lcd_line = 1'b0;
    logic       sig_lcd_frame = 1'b0;
    logic       sig_timer = 1'b0;
    logic       sig_buzz = 1'b0;
    logic       osc1 = 1'b0;
    logic       osc3 = 1'b0;
    logic [4:0] pin_out;

    int n_chk = 0;
    int n_err = 0;
    int last_low = 0;
    int low_run = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sfo_outmux u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pin_data      (pin_data),
        .sig_lcd_line  (sig_lcd_line),
        .sig_lcd_frame (sig_lcd_frame),
        .sig_timer     (sig_timer),
        .sig_buzz      (sig_buzz),
        .osc1          (osc1),
        .osc3          (osc3),
        .pin_out       (pin_out)
    );

    // oscillators, stepped on falling clock edges
    initial begin
        int c1 = 0;
        int c3 = 0;
        forever begin
            @(negedge clk);
            c1++;
            c3++;
            if (c1 == OSC1_HALF) begin osc1 = ~osc1; c1 = 0; end
            if (c3 == OSC3_HALF) begin osc3 = ~osc3; c3 = 0; end
        end
    end

    // low-run monitor for the divided-clock pin
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (pin_out[3] == 1'b0) begin
                low_run++;
            end else if (low_run > 0) begin
                last_low = low_run;
                low_run = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic samp();
        @(posedge clk);
        #2;
    endtask

    task automatic meas(output int hi, output int per);
        int lo;
        hi = 0;
        lo = 0;
        do samp(); while (pin_out[3] != 1'b0);
        do samp(); while (pin_out[3] != 1'b1);
        while (pin_out[3] == 1'b1) begin hi++; samp(); end
        while (pin_out[3] == 1'b0) begin lo++; samp(); end
        per = hi + lo;
    endtask

    task automatic set_sig(input int p, input logic v);
        case (p)
            0: sig_lcd_line = v;
            1: sig_lcd_frame = v;
            2: sig_timer = v;
            default: sig_buzz = v;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int pins[4] = '{0, 1, 2, 4};
        logic [7:0] addrs[4] = '{8'h10, 8'h10, 8'h30, 8'h44};
        int bits[4] = '{4, 3, 2, 0};
        string tags[4] = '{"R2", "R3", "R4", "R5"};
        int hi;
        int per;
        int bad;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sig_lcd_line = 1'b0; sig_lcd_frame = 1'b0; sig_timer = 1'b0; sig_buzz = 1'b1;
        #1;
        chk("R1 pins after reset", int'(pin_out), 32'h0F);
        rd(8'h10, 0, "R1 read 0x10");
        rd(8'h30, 0, "R1 read 0x30");
        rd(8'h40, 0, "R1 read 0x40");
        rd(8'h44, 0, "R1 read 0x44");
        sig_buzz = 1'b0;

        // R2..R5: exhaustive sweep of enable, data and signal per pin
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 2; e++) begin
                wr(addrs[p], 8'(e << bits[p]));
                for (int d = 0; d < 2; d++) begin
                    for (int s = 0; s < 2; s++) begin
                        int exp;
                        @(negedge clk);
                        pin_data[pins[p]] = d[0];
                        set_sig(pins[p], s[0]);
                        #1;
                        if (pins[p] == 4) exp = d | (e & s);
                        else              exp = d & (e ? s : 1);
                        chk(tags[p], int'(pin_out[pins[p]]), exp);
                    end
                end
            end
            wr(addrs[p], 8'h00);
        end
        pin_data = 5'b01111;

        // R6: readback masks and unmapped address
        wr(8'h10, 8'hFF); rd(8'h10, 32'h18, "R6 0x10 mask");
        wr(8'h30, 8'hFF); rd(8'h30, 32'h04, "R6 0x30 mask");
        wr(8'h40, 8'hFF); rd(8'h40, 32'h78, "R6 0x40 mask");
        wr(8'h44, 8'hFF); rd(8'h44, 32'h01, "R6 0x44 mask");
        wr(8'h20, 8'hFF); rd(8'h20, 0, "R6 unmapped");
        wr(8'h10, 8'h00); rd(8'h10, 0, "R6 0x10 clear");
        wr(8'h30, 8'h00); rd(8'h30, 0, "R6 0x30 clear");
        wr(8'h40, 8'h00); rd(8'h40, 0, "R6 0x40 clear");
        wr(8'h44, 8'h00); rd(8'h44, 0, "R6 0x44 clear");

        // R7: disabled divided-clock pin follows its data bit
        for (int d = 0; d < 2; d++) begin
            @(negedge clk);
            pin_data[3] = d[0];
            bad = 0;
            for (int i = 0; i < 40; i++) begin
                samp();
                if (pin_out[3] !== d[0]) bad++;
            end
            chk("R7 disabled pin mismatches", bad, 0);
        end
        pin_data[3] = 1'b1;

        // R8: sweep all eight select values
        for (int sel = 0; sel < 8; sel++) begin
            int src_per;
            int r;
            src_per = (sel >= 4) ? 2 * OSC3_HALF : 2 * OSC1_HALF;
            r = sel % 4;
            wr(8'h40, 8'((sel << 4) | 8'h08));
            meas(hi, per);
            meas(hi, per);
            chk("R8 period", per, src_per << r);
            chk("R8 high time", hi, (src_per << r) / 2);
        end

        // R9: enable from idle, first low phase full length
        wr(8'h40, 8'h00);
        repeat (4) samp();
        chk("R9 idle high", int'(pin_out[3]), 1);
        wr(8'h40, 8'h18);
        do samp(); while (pin_out[3] != 1'b0);
        do samp(); while (pin_out[3] != 1'b1);
        chk("R9 first low phase", last_low, OSC1_HALF * 2);

        // R10: select change written during a low phase
        wr(8'h40, 8'h38);
        meas(hi, per);
        do samp(); while (pin_out[3] != 1'b0);
        wr(8'h40, 8'h48);
        do samp(); while (pin_out[3] != 1'b1);
        chk("R10 low phase kept", last_low, 2 * OSC1_HALF * 4);
        meas(hi, per);
        meas(hi, per);
        chk("R10 new period", per, 2 * OSC3_HALF);
        chk("R10 new high time", hi, OSC3_HALF);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule